// File: doc/BRIEF.md
# UART Receiver Mute and Wakeup Controller

This block sits next to a UART receiver that already handles bit sampling and framing. Each time the receiver completes a word, it sends a one-cycle frame strobe together with the word. Each time it sees a whole frame of idle line, it sends a one-cycle idle strobe. The controller decides whether these events reach the status flags, the receive data register and the interrupt request. Its purpose is to let a node on a shared multiprocessor line ignore traffic that is meant for other nodes.

Software mutes the receiver by writing the control bits with the mute bit set. While muted, incoming words and idle frames set no flag and raise no interrupt. A wake-mode bit selects how hardware ends the mute:

- **Idle wakeup:** the next idle frame unmutes the receiver, and the idle flag stays clear.
- **Address wakeup:** the next word whose most significant bit is 1 is taken as an address. It unmutes the receiver and is delivered like any other received word.

The same control write also sets the wake mode and two interrupt enables.

Top module: `rx_mute_ctrl`

## Requirements
- R1: After reset, `muted`, `rdrf`, `idle_flag` and `irq` are 0, `rx_data` is 0, the wake mode is idle wakeup (0), and both interrupt enables are 0.
- R2: A control write (`sw_wr`=1) with `sw_mute`=1 makes `muted` read 1 from the next cycle.
- R3: When not muted, `frame_done` loads `rx_word` into `rx_data` and sets `rdrf` in the next cycle. When not muted, `idle_seen` sets `idle_flag` in the next cycle.
- R4: While muted, `rdrf` and `idle_flag` never go from 0 to 1, and `rx_data` never changes, except through an address wakeup (R7).
- R5: `irq` is 0 whenever `muted` is 1. Otherwise `irq` is (`rdrf` AND receive enable) OR (`idle_flag` AND idle enable).
- R6: With wake mode 0, an `idle_seen` strobe while muted clears `muted` in the next cycle and leaves `idle_flag` unchanged.
- R7: With wake mode 1, a `frame_done` while muted whose `rx_word` bit DATA_W-1 is 1 does three things in the next cycle: it clears `muted`, loads the word into `rx_data`, and sets `rdrf`.
- R8: The following events are discarded with no effect on any output:
  - while muted in wake mode 1, a word whose bit DATA_W-1 is 0;
  - while muted in wake mode 1, an idle strobe;
  - while muted in wake mode 0, any word.
- R9: A control write with `sw_mute`=1 in the same cycle as a hardware wake event wins. The receiver stays muted, the word is lost, `rdrf` is not set and `rx_data` keeps its value.
- R10: `rdrf_clr` clears `rdrf` and `idle_clr` clears `idle_flag`. If a set and a clear of the same flag arrive in the same cycle, the set wins.
- R11: A control write with `sw_mute`=0 clears `muted` in the next cycle. Wake mode and interrupt enables take the written values from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software control write strobe |
| sw_mute | input | 1 | Mute bit value written |
| sw_wake_sel | input | 1 | Wake mode written (0 idle, 1 address) |
| sw_rx_ie | input | 1 | Receive interrupt enable written |
| sw_idle_ie | input | 1 | Idle interrupt enable written |
| frame_done | input | 1 | Receiver completed a word |
| rx_word | input | DATA_W | Word received with `frame_done` |
| idle_seen | input | 1 | Receiver detected an idle frame |
| rdrf_clr | input | 1 | Software clears the data-ready flag |
| idle_clr | input | 1 | Software clears the idle flag |
| muted | output | 1 | Receiver is muted |
| rdrf | output | 1 | Receive data ready flag |
| idle_flag | output | 1 | Idle line flag |
| rx_data | output | DATA_W | Last delivered word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check a set of local rules on every cycle:

- Each wake event clears the mute state unless a software mute overrides it in the same cycle.
- A software mute always takes effect.
- Unmuted frames set the ready flag.
- While muted, neither flag rises except through an address wake.

Some behaviour is only visible through the bench's scenarios, which a cycle-by-cycle model compares on every clock:

- which wake mode ignores which event;
- the lost address word in the R9 collision;
- set-over-clear priority;
- the exact value of `rx_data` after each kind of wake.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

  typedef enum logic {
    WAKE_ON_IDLE = 1'b0,
    WAKE_ON_ADDR = 1'b1
  } wake_mode_e;

  typedef enum logic {
    RX_LISTEN = 1'b0,
    RX_ASLEEP = 1'b1
  } mute_state_e;

  // A word is an address mark when its top bit is set and address wakeup is selected.
  function automatic logic addr_mark(input logic top_bit, input wake_mode_e mode);
    return top_bit && (mode == WAKE_ON_ADDR);
  endfunction

  // Interrupt request: enabled flags, forced low while asleep.
  function automatic logic irq_merge(input logic asleep, input logic rdy, input logic rdy_en,
                                     input logic idl, input logic idl_en);
    return !asleep && ((rdy && rdy_en) || (idl && idl_en));
  endfunction

endpackage

// File: rtl/rxm_ctrl_regs.sv
module rxm_ctrl_regs
  import rxm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_wr,
  input  logic       sw_wake_sel,
  input  logic       sw_rx_ie,
  input  logic       sw_idle_ie,
  output wake_mode_e wake_mode,
  output logic       rx_ie,
  output logic       idle_ie
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_mode <= WAKE_ON_IDLE;
      rx_ie     <= 1'b0;
      idle_ie   <= 1'b0;
    end else if (sw_wr) begin
      wake_mode <= wake_mode_e'(sw_wake_sel);
      rx_ie     <= sw_rx_ie;
      idle_ie   <= sw_idle_ie;
    end
  end

endmodule

// File: rtl/rxm_wake_detect.sv
module rxm_wake_detect
  import rxm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              asleep,
  input  wake_mode_e        wake_mode,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              idle_seen,
  input  logic              sw_wr,
  input  logic              sw_mute,
  output logic              sw_hold,
  output logic              idle_wake,
  output logic              addr_wake,
  output logic              wake_evt,
  output logic              take_word,
  output logic              idle_set
);

  localparam int TOP = DATA_W - 1;

  logic is_mark;

  always_comb begin
    is_mark   = addr_mark(rx_word[TOP], wake_mode);
    sw_hold   = sw_wr && sw_mute;
    idle_wake = asleep && idle_seen && (wake_mode == WAKE_ON_IDLE);
    addr_wake = asleep && frame_done && is_mark;
    wake_evt  = idle_wake || addr_wake;
    // A word is delivered when listening, or when it is the waking address
    // and software is not re-muting in the same cycle.
    take_word = frame_done && (!asleep || (addr_wake && !sw_hold));
    // An idle frame sets the flag only when listening; an idle wake never does.
    idle_set  = idle_seen && !asleep;
  end

endmodule

// File: rtl/rxm_mute_fsm.sv
module rxm_mute_fsm
  import rxm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_mute,
  input  logic sw_hold,
  input  logic wake_evt,
  output logic asleep
);

  mute_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (sw_wr) begin
      state_d = sw_mute ? RX_ASLEEP : RX_LISTEN;
    end else if (wake_evt) begin
      state_d = RX_LISTEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_LISTEN;
    else        state_q <= state_d;
  end

  assign asleep = (state_q == RX_ASLEEP);

  assert_sw_mute_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hold |=> asleep);

  assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake_evt && !sw_wr) |=> !asleep);

  assert_sw_unmute_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !sw_mute) |=> !asleep);

endmodule

// File: rtl/rxm_status.sv
module rxm_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asleep,
  input  logic              take_word,
  input  logic              idle_set,
  input  logic              addr_wake,
  input  logic              sw_hold,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rdrf_clr,
  input  logic              idle_clr,
  output logic              rdrf,
  output logic              idle_flag,
  output logic [DATA_W-1:0] rx_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdrf      <= 1'b0;
      idle_flag <= 1'b0;
      rx_data   <= '0;
    end else begin
      if (take_word) begin
        rdrf    <= 1'b1;
        rx_data <= rx_word;
      end else if (rdrf_clr) begin
        rdrf    <= 1'b0;
      end
      if (idle_set)      idle_flag <= 1'b1;
      else if (idle_clr) idle_flag <= 1'b0;
    end
  end

  assert_muted_no_rdrf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !addr_wake && !rdrf) |=> !rdrf);

  assert_muted_no_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !idle_flag) |=> !idle_flag);

  assert_addr_lost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && sw_hold && !rdrf) |=> !rdrf);

  assert_ready_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_word |=> rdrf);

endmodule

// File: rtl/rx_mute_ctrl.sv
module rx_mute_ctrl
  import rxm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_mute,
  input  logic              sw_wake_sel,
  input  logic              sw_rx_ie,
  input  logic              sw_idle_ie,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              idle_seen,
  input  logic              rdrf_clr,
  input  logic              idle_clr,
  output logic              muted,
  output logic              rdrf,
  output logic              idle_flag,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq
);

  wake_mode_e wake_mode;
  logic rx_ie, idle_ie;
  logic sw_hold, idle_wake, addr_wake, wake_evt, take_word, idle_set;

  rxm_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wake_sel(sw_wake_sel),
    .sw_rx_ie(sw_rx_ie), .sw_idle_ie(sw_idle_ie),
    .wake_mode(wake_mode), .rx_ie(rx_ie), .idle_ie(idle_ie)
  );

  rxm_wake_detect #(.DATA_W(DATA_W)) u_wake (
    .asleep(muted), .wake_mode(wake_mode), .frame_done(frame_done),
    .rx_word(rx_word), .idle_seen(idle_seen), .sw_wr(sw_wr), .sw_mute(sw_mute),
    .sw_hold(sw_hold), .idle_wake(idle_wake), .addr_wake(addr_wake),
    .wake_evt(wake_evt), .take_word(take_word), .idle_set(idle_set)
  );

  rxm_mute_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_mute(sw_mute),
    .sw_hold(sw_hold), .wake_evt(wake_evt), .asleep(muted)
  );

  rxm_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .asleep(muted), .take_word(take_word),
    .idle_set(idle_set), .addr_wake(addr_wake), .sw_hold(sw_hold),
    .rx_word(rx_word), .rdrf_clr(rdrf_clr), .idle_clr(idle_clr),
    .rdrf(rdrf), .idle_flag(idle_flag), .rx_data(rx_data)
  );

  assign irq = irq_merge(muted, rdrf, rx_ie, idle_flag, idle_ie);

  assert_idle_wake_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wake && !idle_flag) |=> !idle_flag);

  assert_addr_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wake && !sw_wr) |=> (rdrf && !muted && rx_data == $past(rx_word)));

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && $stable(muted)) |-> !irq);

endmodule

// File: tb/test_rx_mute_ctrl.sv
`timescale 1ns/1ps
module test_rx_mute_ctrl;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr = 0, sw_mute = 0, sw_wake_sel = 0, sw_rx_ie = 0, sw_idle_ie = 0;
  logic frame_done = 0, idle_seen = 0, rdrf_clr = 0, idle_clr = 0;
  logic [W-1:0] rx_word = '0;
  logic muted, rdrf, idle_flag, irq;
  logic [W-1:0] rx_data;

  int checks = 0;
  int errors = 0;

  // reference state
  bit m_muted, m_mode, m_rie, m_iie, m_rdrf, m_idle;
  int m_data;

  always #5 clk = ~clk;

  rx_mute_ctrl #(.DATA_W(W)) i_rx_mute_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_mute(sw_mute),
    .sw_wake_sel(sw_wake_sel), .sw_rx_ie(sw_rx_ie), .sw_idle_ie(sw_idle_ie),
    .frame_done(frame_done), .rx_word(rx_word), .idle_seen(idle_seen),
    .rdrf_clr(rdrf_clr), .idle_clr(idle_clr), .muted(muted), .rdrf(rdrf),
    .idle_flag(idle_flag), .rx_data(rx_data), .irq(irq)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    bit exp_irq;
    exp_irq = !m_muted && ((m_rdrf && m_rie) || (m_idle && m_iie));
    cmp(req, "muted", int'(muted), int'(m_muted));
    cmp(req, "rdrf", int'(rdrf), int'(m_rdrf));
    cmp(req, "idle_flag", int'(idle_flag), int'(m_idle));
    cmp(req, "rx_data", int'(rx_data), m_data);
    cmp(req, "irq", int'(irq), int'(exp_irq));
  endtask

  // Apply current inputs for one clock; advance model; compare at negedge.
  task automatic step(input string req);
    bit waking, hold, deliver, top;
    top    = rx_word[W-1];
    waking = 0;
    if (m_muted) begin
      if (m_mode == 0 && idle_seen) waking = 1;
      if (m_mode == 1 && frame_done && top) waking = 1;
    end
    hold    = sw_wr && sw_mute;
    deliver = 0;
    if (frame_done) begin
      if (!m_muted) deliver = 1;
      else if (m_mode == 1 && top && !hold) deliver = 1;
    end
    @(posedge clk);
    if (deliver) begin m_rdrf = 1; m_data = int'(rx_word); end
    else if (rdrf_clr) m_rdrf = 0;
    if (idle_seen && !m_muted) m_idle = 1;
    else if (idle_clr) m_idle = 0;
    if (sw_wr) begin
      m_muted = sw_mute; m_mode = sw_wake_sel; m_rie = sw_rx_ie; m_iie = sw_idle_ie;
    end else if (waking) m_muted = 0;
    @(negedge clk);
    sw_wr = 0; frame_done = 0; idle_seen = 0; rdrf_clr = 0; idle_clr = 0;
    compare_all(req);
  endtask

  task automatic wr_ctrl(input bit mute, input bit mode, input bit rie, input bit iie);
    sw_wr = 1; sw_mute = mute; sw_wake_sel = mode; sw_rx_ie = rie; sw_idle_ie = iie;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_muted = 0; m_mode = 0; m_rie = 0; m_iie = 0; m_rdrf = 0; m_idle = 0; m_data = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    @(negedge clk);
    compare_all("R1");

    wr_ctrl(0, 0, 1, 1); step("R11");
    rx_word = 8'h35; frame_done = 1; step("R3");
    compare_all("R5");
    rdrf_clr = 1; step("R10");
    rx_word = 8'h4C; frame_done = 1; rdrf_clr = 1; step("R10");
    idle_seen = 1; step("R3");
    idle_seen = 1; idle_clr = 1; step("R10");
    idle_clr = 1; step("R10");

    // mute in idle mode, rdrf left set: irq must be masked
    wr_ctrl(1, 0, 1, 1); step("R2");
    compare_all("R5");
    rx_word = 8'hF0; frame_done = 1; step("R8");
    rx_word = 8'h12; frame_done = 1; step("R4");
    idle_seen = 1; step("R6");
    rdrf_clr = 1; step("R10");

    // address mode
    wr_ctrl(1, 1, 1, 0); step("R2");
    rx_word = 8'h7E; frame_done = 1; step("R8");
    idle_seen = 1; step("R8");
    rx_word = 8'hA7; frame_done = 1; step("R7");
    rx_word = 8'h21; frame_done = 1; step("R3");

    // collision: software re-mute with address wake
    wr_ctrl(1, 1, 1, 0); step("R2");
    rdrf_clr = 1; step("R10");
    rx_word = 8'h91; frame_done = 1; wr_ctrl(1, 1, 1, 0); step("R9");
    rx_word = 8'h88; frame_done = 1; step("R7");

    // collision in idle mode
    wr_ctrl(1, 0, 0, 1); step("R2");
    idle_seen = 1; wr_ctrl(1, 0, 0, 1); step("R9");
    wr_ctrl(0, 0, 0, 1); step("R11");

    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      sw_wr = ((r & 15) == 0);
      sw_mute = r[4]; sw_wake_sel = r[5]; sw_rx_ie = r[6]; sw_idle_ie = r[7];
      frame_done = r[8] & r[9];
      rx_word = W'(r >> 16);
      idle_seen = r[10] & r[11] & r[12];
      rdrf_clr = r[13] & r[14];
      idle_clr = r[15] & r[3];
      step("R4");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule